// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a character-level serial engine and an infrared transceiver. On transmit it takes one byte and sends it as an asynchronous character. Every 0 bit cell carries one short light pulse at its leading edge. Every 1 bit cell stays dark. Since the start bit is always 0, each character opens with a pulse. On receive it watches the photodiode line. It treats the first pulse after idle as a start bit and aligns its bit timing to that pulse. It then rebuilds the character and reports parity and stop-bit violations.

Timing comes from a single-cycle enable, `tick16`, that runs at sixteen times the bit rate. The block does not generate that rate itself. The link is half duplex, so a character in flight in one direction locks out the other direction until it ends. Frame options are sampled when a character starts: parity on or off, odd or even, and one or two stop bits.

Top module: `sir_codec`

## Requirements
- R1: After reset `ir_tx`, `busy` and `rx_valid` are 0.
- R2: Each bit cell lasts 16 ticks. A 0 bit drives `ir_tx` high for exactly the first 3 ticks of its cell. A 1 bit keeps `ir_tx` low for the whole cell.
- R3: A transmitted character is sent in this cell order: a start bit of 0, then the 8 data bits LSB first, then the parity bit if `cfg_par_en` is set, then one stop bit of 1, or two stop bits when `cfg_stop2` is set.
- R4: With `cfg_par_odd`=0 the parity bit is the XOR of the 8 data bits. With `cfg_par_odd`=1 it is the inverse of that XOR.
- R5: When `tx_start` is accepted at a clock edge, `busy` is high from the next cycle. `ir_tx` is high from that cycle, because it carries the start pulse. `busy` falls at the tick that ends the last stop cell. A `tx_start` raised while a character is being sent is ignored.
- R6: In idle, a rising edge on `ir_rx` marks the start bit and resets the bit timing. For each later data or parity cell, a rising edge anywhere in that 16-tick window gives a 0, and no edge gives a 1.
- R7: `rx_valid` is high for one cycle, just after the tick that closes the last stop window. `rx_data`, `rx_perr` and `rx_ferr` keep their values until the next character completes.
- R8: `rx_perr` is 1 when parity is enabled and the received parity bit differs from the R4 rule applied to the received data. Otherwise it is 0.
- R9: `rx_ferr` is 1 when a rising edge on `ir_rx` falls inside any stop window.
- R10: While a character is being transmitted, `ir_rx` edges start no reception. While a character is being received, `tx_start` is ignored and `ir_tx` stays low. If both directions would start in the same cycle, transmit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| ir_rx | input | 1 | Received pulse line, high while light is seen |
| ir_tx | output | 1 | Transmit pulse line, high to emit light |
| busy | output | 1 | A character is in flight in either direction |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_data | output | 8 | Last received byte |
| rx_perr | output | 1 | Parity error of the last received byte |
| rx_ferr | output | 1 | Stop-bit violation of the last received byte |

## Verification
The assertions take two things for granted about the inputs. First, `tick16` is a single-cycle pulse whose spacing exceeds the latency of the input synchronizer. Second, received pulses start near a cell boundary and end well before the next one, so every edge lands in the window it belongs to. The stimulus follows both rules: it raises the tick once every four clocks, and it changes `ir_rx` only on the falling clock edge right after a tick. That places each detected edge two to three cycles after the window boundary it belongs to. Pulses shifted deep into a cell are also sent, and they are kept short enough to end before the cell closes.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
  } sir_cfg_t;

  typedef enum logic [0:0] {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } sir_rx_st_e;

  // cells beyond the data bits: start, one stop, optional parity and second stop
  function automatic logic [2:0] sir_extra_cells(sir_cfg_t c);
    return 3'd2 + {2'b0, c.par_en} + {2'b0, c.stop2};
  endfunction

endpackage

// File: rtl/sir_tx.sv
module sir_tx
  import sir_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  sir_cfg_t          cfg,
  output logic              active,
  output logic              ir_tx
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int TCNT_W  = $clog2(OVS);

  logic               active_q, act_n;
  logic [FRAME_W-1:0] frame_q, fr_n, fr_load;
  logic [CNT_W-1:0]   left_q, left_n, len_load;
  logic [TCNT_W-1:0]  tcnt_q, tc_n;
  logic               ir_q, pulse_n;

  always_comb begin
    fr_load              = '1;
    fr_load[0]           = 1'b0;
    fr_load[DATA_W:1]    = data;
    if (cfg.par_en)
      fr_load[DATA_W+1]  = cfg.par_odd ^ (^data);
    len_load = CNT_W'(DATA_W) + CNT_W'(sir_extra_cells(cfg));
  end

  always_comb begin
    act_n  = active_q;
    fr_n   = frame_q;
    left_n = left_q;
    tc_n   = tcnt_q;
    if (!active_q) begin
      if (go) begin
        act_n  = 1'b1;
        fr_n   = fr_load;
        left_n = len_load;
        tc_n   = '0;
      end
    end else if (tick16) begin
      if (tcnt_q == TCNT_W'(OVS - 1)) begin
        tc_n = '0;
        if (left_q == CNT_W'(1)) begin
          act_n = 1'b0;
        end else begin
          left_n = left_q - CNT_W'(1);
          fr_n   = {1'b1, frame_q[FRAME_W-1:1]};
        end
      end else begin
        tc_n = tcnt_q + TCNT_W'(1);
      end
    end
    pulse_n = act_n && !fr_n[0] && (tc_n < TCNT_W'(PULSE_TICKS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      left_q   <= '0;
      tcnt_q   <= '0;
      ir_q     <= 1'b0;
    end else begin
      active_q <= act_n;
      frame_q  <= fr_n;
      left_q   <= left_n;
      tcnt_q   <= tc_n;
      ir_q     <= pulse_n;
    end
  end

  assign active = active_q;
  assign ir_tx  = ir_q;

  // pulse length monitor, in ticks
  logic [3:0] pw_q;
  always_ff @(posedge clk) begin
    if (rst || !ir_q) pw_q <= '0;
    else if (tick16 && pw_q != 4'hF) pw_q <= pw_q + 4'd1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    pw_q <= 4'(PULSE_TICKS)); // R2

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (active_q && go && !tick16) |=> $stable(frame_q) && $stable(left_q)); // R5

endmodule

// File: rtl/sir_rx_front.sv
module sir_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ir_rx,
  output logic rise
);

  logic synced;
  logic prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= ir_rx;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[SYNC_STAGES-2:0], ir_rx};
      end
      assign synced = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  assign rise = synced & ~prev_q;

endmodule

// File: rtl/sir_rx.sv
module sir_rx
  import sir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rise,
  input  logic              blocked,
  input  sir_cfg_t          cfg,
  output logic              active,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              perr,
  output logic              ferr
);

  localparam int IDX_W  = $clog2(DATA_W + 4);
  localparam int TCNT_W = $clog2(OVS);

  sir_rx_st_e         st_q;
  sir_cfg_t           cfg_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic [IDX_W-1:0]   idx_q, last_idx, par_idx;
  logic               hit_q, par_q, ferr_acc;
  logic [DATA_W-1:0]  shift_q, data_q;
  logic               valid_q, perr_q, ferr_q;
  logic               close, seen, bitv, is_data, is_par;

  assign last_idx = IDX_W'(DATA_W + 1) + IDX_W'(cfg_q.par_en) + IDX_W'(cfg_q.stop2);
  assign par_idx  = IDX_W'(DATA_W + 1);
  assign close    = (st_q == RX_FRAME) && tick16 && (tcnt_q == TCNT_W'(OVS - 1));
  assign seen     = hit_q | rise;
  assign bitv     = ~seen;
  assign is_data  = (idx_q != '0) && (idx_q <= IDX_W'(DATA_W));
  assign is_par   = cfg_q.par_en && (idx_q == par_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= RX_IDLE;
      cfg_q    <= '0;
      tcnt_q   <= '0;
      idx_q    <= '0;
      hit_q    <= 1'b0;
      par_q    <= 1'b0;
      ferr_acc <= 1'b0;
      shift_q  <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (rise && !blocked) begin
            st_q     <= RX_FRAME;
            cfg_q    <= cfg;
            tcnt_q   <= '0;
            idx_q    <= '0;
            hit_q    <= 1'b0;
            ferr_acc <= 1'b0;
          end
        end
        default: begin
          if (close) begin
            tcnt_q <= '0;
            hit_q  <= 1'b0;
            idx_q  <= idx_q + IDX_W'(1);
            if (is_data)
              shift_q <= {bitv, shift_q[DATA_W-1:1]};
            else if (is_par)
              par_q <= bitv;
            else if (idx_q != '0)
              ferr_acc <= ferr_acc | seen;
            if (idx_q == last_idx) begin
              st_q    <= RX_IDLE;
              valid_q <= 1'b1;
              data_q  <= shift_q;
              perr_q  <= cfg_q.par_en && (par_q != (cfg_q.par_odd ^ (^shift_q)));
              ferr_q  <= ferr_acc | seen;
            end
          end else begin
            if (tick16) tcnt_q <= tcnt_q + TCNT_W'(1);
            if (rise)   hit_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign active = (st_q == RX_FRAME);
  assign data   = data_q;
  assign valid  = valid_q;
  assign perr   = perr_q;
  assign ferr   = ferr_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(data_q) && $stable(perr_q) && $stable(ferr_q)); // R7

  AST_NO_START_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_IDLE && blocked) |=> st_q == RX_IDLE); // R10

endmodule

// File: rtl/sir_codec.sv
module sir_codec
  import sir_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ir_rx,
  output logic              ir_tx,
  output logic              busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr
);

  sir_cfg_t cfg;
  logic     tx_active, rx_active, tx_go, rx_block, rise;

  assign cfg      = '{par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign tx_go    = tx_start & ~rx_active;
  assign rx_block = tx_active | tx_start;
  assign busy     = tx_active | rx_active;

  sir_tx #(
    .DATA_W(DATA_W), .OVS(OVS), .PULSE_TICKS(PULSE_TICKS)
  ) u_tx (
    .clk(clk), .rst(rst), .tick16(tick16), .go(tx_go), .data(tx_data),
    .cfg(cfg), .active(tx_active), .ir_tx(ir_tx)
  );

  sir_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .ir_rx(ir_rx), .rise(rise)
  );

  sir_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rise(rise), .blocked(rx_block),
    .cfg(cfg), .active(rx_active), .data(rx_data), .valid(rx_valid),
    .perr(rx_perr), .ferr(rx_ferr)
  );

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    !(tx_active && rx_active)); // R10

  AST_DARK_WHILE_RX: assert property (@(posedge clk) disable iff (rst)
    rx_active |-> !ir_tx); // R10

endmodule

// File: tb/tb_sir_codec.sv
module tb_sir_codec;

  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       tx_start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       ir_rx = 1'b0;
  logic       ir_tx, busy, rx_valid, rx_perr, rx_ferr;
  logic [7:0] rx_data;

  int nchk = 0, nfail = 0, vcnt = 0, txhigh = 0;

  always #2 clk = ~clk;

  sir_codec dut (
    .clk(clk), .rst(rst), .tick16(tick16), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .tx_start(tx_start),
    .tx_data(tx_data), .ir_rx(ir_rx), .ir_tx(ir_tx), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) begin
    if (rx_valid) vcnt++;
    if (ir_tx)    txhigh++;
  end

  // {stop_pulse, flip_par, stop2, par_odd, par_en, data}
  localparam logic [12:0] VEC [8] = '{
    {5'b00000, 8'h55}, {5'b00001, 8'hA3}, {5'b00011, 8'hA3}, {5'b00100, 8'h00},
    {5'b00111, 8'hFF}, {5'b01001, 8'h3C}, {5'b10000, 8'h81}, {5'b11111, 8'h6E}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    repeat (TDIV - 1) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic pe,
      input logic po, input logic s2, input logic flip, input logic sp, output int n);
    logic [11:0] b = '1;
    b[0]   = 1'b0;
    b[8:1] = d;
    n = 10 + int'(pe) + int'(s2);
    if (pe) b[9] = po ^ (^d) ^ flip;
    if (sp) b[n-1] = 1'b0;
    return b;
  endfunction

  task automatic tx_frame(input logic [7:0] d, input logic pe, input logic po,
      input logic s2, input logic noise, input logic poke);
    int n, mism, vbefore;
    logic [11:0] b;
    b = frame_bits(d, pe, po, s2, 1'b0, 1'b0, n);
    cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    vbefore = vcnt;
    tx_data = d; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk("R5 busy after start", busy, 1);
    mism = 0;
    for (int k = 0; k < n * 16; k++) begin
      if (ir_tx !== (!b[k/16] && (k % 16) < 3)) mism++;
      if (!busy) mism++;
      ir_rx    = noise && k < 64 && (k % 16) < 3;
      tx_start = poke && k == 20;
      if (poke && k == 20) tx_data = ~d;
      do_tick();
    end
    tx_start = 1'b0;
    ir_rx    = 1'b0;
    chk("R2 R3 R4 pulse pattern mismatches", mism, 0);
    chk("R5 busy after last stop", busy, 0);
    chk("R2 dark after frame", ir_tx, 0);
    if (noise) chk("R10 no reception during tx", vcnt - vbefore, 0);
    repeat (4) do_tick();
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic pe, input logic po,
      input logic s2, input logic flip, input logic sp, input int off, input logic poke);
    int n, hbefore;
    logic [11:0] b;
    b = frame_bits(d, pe, po, s2, flip, sp, n);
    cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    hbefore = txhigh;
    for (int k = 0; k < n * 16; k++) begin
      if (k < 16) ir_rx = (k % 16) < 3;
      else if (k / 16 >= n - 1 - int'(s2)) ir_rx = !b[k/16] && (k % 16) < 3;
      else ir_rx = !b[k/16] && (k % 16) >= off && (k % 16) < off + 3;
      tx_start = poke && k == 40;
      do_tick();
    end
    tx_start = 1'b0;
    ir_rx    = 1'b0;
    chk("R7 rx_valid at end", rx_valid, 1);
    chk("R6 rx_data", rx_data, d);
    chk("R8 rx_perr", rx_perr, pe && flip);
    chk("R9 rx_ferr", rx_ferr, sp);
    if (poke) chk("R10 ir_tx dark during rx", txhigh - hbefore, 0);
    @(negedge clk);
    chk("R7 rx_valid one cycle", rx_valid, 0);
    chk("R7 rx_data held", rx_data, d);
    repeat (4) do_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R5 watchdog: busy=%0b expected=0", busy);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ir_tx reset", ir_tx, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 rx_valid reset", rx_valid, 0);

    for (int i = 0; i < 8; i++) begin
      tx_frame(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10], 1'b0, 1'b0);
      rx_frame(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10], VEC[i][11], VEC[i][12], 0, 1'b0);
    end

    // R6: pulses late in the cell still decode as 0
    rx_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10, 1'b0);
    // R5: second start during transmission is ignored
    tx_frame(8'hC6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R10: receive line activity during transmission
    tx_frame(8'hF0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10 no stray reception after tx", busy, 0);
    // R10: transmit request during reception
    rx_frame(8'h2D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1);
    chk("R10 request dropped", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule